// File: doc/BRIEF.md
# Modulator Clock Source Synchroniser

This block chooses the clock that paces a switching-amplifier modulator and lets several such devices share one clock as a master-slave chain. The block is clocked by the local oscillator, `osc_clk`. It derives the internal modulator clock from that oscillator at half its rate. One internal clock cycle is therefore two `osc_clk` cycles. This lets the modulator clock and the sync output be carried as ordinary registered signals.

Once the active-low shutdown input is released, the block spends one internal cycle in a reference phase. It then runs a 127-cycle training window, during which it drives the internal clock onto `sync_out`. At the end of the window it looks at `sync_in`. If `sync_in` is static, the modulator stays on the internal clock and `sync_out` goes quiet. If `sync_in` toggles, the block emits one short irregular pulse and then forwards the synchronised external clock on both the modulator clock and `sync_out`. While running, it can move from the internal clock to the external clock: it first echoes a few internal cycles on `sync_out`. It can also move from the external clock back to the internal clock when the external clock has been absent for a fixed interval.

Top module: `msync_top`

## Requirements
- R1: While `rst_n` or `shdn_n` is low, `mod_clk`, `sync_out`, `mode_int`, `mode_ext`, `training` and `locked` are all 0.
- R2: Count the `osc_clk` edges after `shdn_n` is sampled high, starting at 1. `training` is 0 after edge 2. It is 1 from edge 3 through edge 256, which is 127 internal cycles. It is 0 after edge 257.
- R3: During training, `sync_out` and `mod_clk` carry the internal clock. The internal clock is 1 after every even edge counted as in R2 and 0 after every odd edge.
- R4: If `sync_in` shows no edge in the final 16 internal cycles of training, `mode_int` is 1 after edge 257. `mod_clk` then follows the internal clock, and `sync_out` stays 0 for as long as `sync_in` stays static.
- R5: If `sync_in` toggled within the final 16 internal cycles of training, `mode_ext` is 1 after edge 257. `mod_clk` is 1 for exactly that one cycle, the irregular pulse. After edge 258, `mod_clk` and `locked` are 0, and `locked` rises after the synchronised `sync_in` is next seen low.
- R6: While `locked` is 1, `sync_out` and `mod_clk` equal the value `sync_in` had two `osc_clk` edges earlier.
- R7: In internal mode, a `sync_in` edge starts acquisition. For at least 4 internal cycles, `sync_out` carries the internal clock and `mode_int` stays 1. After that, the block locks to the external clock if `sync_in` is still toggling.
- R8: When `sync_in` stops toggling in external mode, `sync_out` goes static two edges later. After 16 internal cycles with no edge, `locked` falls and `mode_int` rises.
- R9: At most one of `mode_int`, `mode_ext` and `training` is 1, and `locked` is 1 only together with `mode_ext`.
- R10: Driving `shdn_n` low in any mode clears every output and flag after the next `osc_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown; synchronisation starts when it is released |
| sync_in | input | 1 | External sync clock or static level |
| mod_clk | output | 1 | Clock handed to the modulator |
| sync_out | output | 1 | Sync clock passed on to the next device in the chain |
| mode_int | output | 1 | Modulator runs on the internal clock (including acquisition) |
| mode_ext | output | 1 | Modulator is switching to, or runs on, the external clock |
| training | output | 1 | Training window is active |
| locked | output | 1 | Modulator follows the external clock |

## Verification
Each check is queued with the exact `osc_clk` edge at which its result is due, counted from the stimulus. The reference phase and training end are due at edges 3 and 257 after release. A forwarded `sync_in` value appears two edges after the half-cycle on which it was driven. A shutdown shows one edge later. Where the start of an event depends on where the external clock's phase falls, such as acquisition start or loss detection, the due edge is chosen inside the interval that every phase allows, and the monitor compares only at that edge. Internal-clock values are predicted from the parity of the edge count since the last release.

// File: rtl/msync_pkg.sv
package msync_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_REF,
        ST_TRAIN,
        ST_INT,
        ST_ACQ,
        ST_PULSE,
        ST_GATE,
        ST_EXT
    } seq_state_e;

endpackage

// File: rtl/msync_osc.sv
module msync_osc (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic run,
    output logic int_clk
);

    typedef struct packed {
        logic ph;
    } osc_t;

    osc_t osc_d, osc_q;

    always_comb begin
        osc_d = osc_q;
        if (run) begin
            osc_d.ph = ~osc_q.ph;
        end else begin
            osc_d.ph = 1'b0;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q <= '0;
        end else begin
            osc_q <= osc_d;
        end
    end

    assign int_clk = osc_q.ph;

    p_stopped_low_r1: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !run |=> !int_clk);

endmodule

// File: rtl/msync_activity.sv
module msync_activity #(
    parameter int STAGES   = 2,
    parameter int LOSS_LEN = 32
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sync_in,
    output logic sync_s,
    output logic edge_seen,
    output logic alive
);

    localparam int IW = $clog2(LOSS_LEN + 1);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
        logic [IW-1:0]     idle;
    } act_t;

    act_t act_d, act_q;

    always_comb begin
        act_d      = act_q;
        act_d.sh   = {act_q.sh[STAGES-2:0], sync_in};
        act_d.last = act_q.sh[STAGES-1];
        if (clear) begin
            act_d.idle = IW'(LOSS_LEN);
        end else if (act_q.sh[STAGES-1] ^ act_q.last) begin
            act_d.idle = '0;
        end else if (act_q.idle < IW'(LOSS_LEN)) begin
            act_d.idle = act_q.idle + 1'b1;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q      <= '0;
            act_q.idle <= IW'(LOSS_LEN);
        end else begin
            act_q <= act_d;
        end
    end

    assign sync_s    = act_q.sh[STAGES-1];
    assign edge_seen = act_q.sh[STAGES-1] ^ act_q.last;
    assign alive     = act_q.idle < IW'(LOSS_LEN);

    p_idle_cap_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        act_q.idle <= IW'(LOSS_LEN));

    p_edge_revives_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (edge_seen && !clear) |=> alive);

endmodule

// File: rtl/msync_seq.sv
module msync_seq
    import msync_pkg::*;
#(
    parameter int REF_CYC   = 1,
    parameter int TRAIN_CYC = 127,
    parameter int ACQ_CYC   = 4
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       shdn_n,
    input  logic       int_clk,
    input  logic       sync_s,
    input  logic       edge_seen,
    input  logic       alive,
    output seq_state_e state
);

    localparam int REF_LEN   = 2 * REF_CYC;
    localparam int TRAIN_LEN = 2 * TRAIN_CYC;
    localparam int ACQ_LEN   = 2 * ACQ_CYC;
    localparam int MAX_LEN   = (TRAIN_LEN > ACQ_LEN) ?
                               ((TRAIN_LEN > REF_LEN) ? TRAIN_LEN : REF_LEN) :
                               ((ACQ_LEN > REF_LEN) ? ACQ_LEN : REF_LEN);
    localparam int CW        = $clog2(MAX_LEN + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.cnt = seq_q.cnt + 1'b1;
        if (!shdn_n) begin
            seq_d.st  = ST_OFF;
            seq_d.cnt = '0;
        end else begin
            unique case (seq_q.st)
                ST_OFF: begin
                    seq_d.st  = ST_REF;
                    seq_d.cnt = '0;
                end
                ST_REF: begin
                    if (seq_q.cnt == CW'(REF_LEN - 1)) begin
                        seq_d.st  = ST_TRAIN;
                        seq_d.cnt = '0;
                    end
                end
                ST_TRAIN: begin
                    if (seq_q.cnt == CW'(TRAIN_LEN - 1)) begin
                        seq_d.st  = alive ? ST_PULSE : ST_INT;
                        seq_d.cnt = '0;
                    end
                end
                ST_INT: begin
                    seq_d.cnt = '0;
                    if (edge_seen) begin
                        seq_d.st = ST_ACQ;
                    end
                end
                ST_ACQ: begin
                    if (seq_q.cnt >= CW'(ACQ_LEN - 1)) begin
                        seq_d.cnt = seq_q.cnt;
                        if (!int_clk) begin
                            seq_d.st  = alive ? ST_GATE : ST_INT;
                            seq_d.cnt = '0;
                        end
                    end
                end
                ST_PULSE: begin
                    seq_d.st  = ST_GATE;
                    seq_d.cnt = '0;
                end
                ST_GATE: begin
                    seq_d.cnt = '0;
                    if (!alive && !int_clk) begin
                        seq_d.st = ST_INT;
                    end else if (!sync_s) begin
                        seq_d.st = ST_EXT;
                    end
                end
                ST_EXT: begin
                    seq_d.cnt = '0;
                    if (!alive && !int_clk) begin
                        seq_d.st = ST_INT;
                    end
                end
                default: begin
                    seq_d.st  = ST_OFF;
                    seq_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_OFF, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;

    p_ref_to_train_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ($past(seq_q.st) == ST_REF && seq_q.st != ST_REF && $past(shdn_n))
        |-> seq_q.st == ST_TRAIN);

    p_train_exit_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ($past(seq_q.st) == ST_TRAIN && seq_q.st != ST_TRAIN && $past(shdn_n))
        |-> (seq_q.st == ST_INT || seq_q.st == ST_PULSE));

endmodule

// File: rtl/msync_top.sv
module msync_top
    import msync_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REF_CYC     = 1,
    parameter int TRAIN_CYC   = 127,
    parameter int ACQ_CYC     = 4,
    parameter int LOSS_CYC    = 16
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic shdn_n,
    input  logic sync_in,
    output logic mod_clk,
    output logic sync_out,
    output logic mode_int,
    output logic mode_ext,
    output logic training,
    output logic locked
);

    localparam int LOSS_LEN = 2 * LOSS_CYC;

    seq_state_e state;
    logic       int_clk;
    logic       sync_s;
    logic       edge_seen;
    logic       alive;
    logic       osc_run;

    assign osc_run = (state != ST_OFF);

    msync_osc u_osc (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .run     (osc_run),
        .int_clk (int_clk)
    );

    msync_activity #(
        .STAGES   (SYNC_STAGES),
        .LOSS_LEN (LOSS_LEN)
    ) u_act (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .clear     (state == ST_OFF),
        .sync_in   (sync_in),
        .sync_s    (sync_s),
        .edge_seen (edge_seen),
        .alive     (alive)
    );

    msync_seq #(
        .REF_CYC   (REF_CYC),
        .TRAIN_CYC (TRAIN_CYC),
        .ACQ_CYC   (ACQ_CYC)
    ) u_seq (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .shdn_n    (shdn_n),
        .int_clk   (int_clk),
        .sync_s    (sync_s),
        .edge_seen (edge_seen),
        .alive     (alive),
        .state     (state)
    );

    always_comb begin
        mod_clk  = 1'b0;
        sync_out = 1'b0;
        unique case (state)
            ST_TRAIN, ST_ACQ: begin
                mod_clk  = int_clk;
                sync_out = int_clk;
            end
            ST_INT:   mod_clk = int_clk;
            ST_PULSE: mod_clk = 1'b1;
            ST_EXT: begin
                mod_clk  = sync_s;
                sync_out = sync_s;
            end
            default: begin
                mod_clk  = 1'b0;
                sync_out = 1'b0;
            end
        endcase
    end

    assign training = (state == ST_TRAIN);
    assign mode_int = (state == ST_INT) || (state == ST_ACQ);
    assign mode_ext = (state == ST_PULSE) || (state == ST_GATE) || (state == ST_EXT);
    assign locked   = (state == ST_EXT);

    p_quiet_r1: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !shdn_n |=> (!mod_clk && !sync_out && !locked));

    p_train_toggle_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (training && $past(training)) |-> (sync_out != $past(sync_out)));

    p_int_clock_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state == ST_INT && $past(state) == ST_INT) |-> (mod_clk != $past(mod_clk)));

    p_pulse_high_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ($past(training) && mode_ext) |-> mod_clk);

    p_pulse_single_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ($past(training) && mode_ext && shdn_n) |=> !mod_clk);

    p_follow_r6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        locked |-> (sync_out == mod_clk));

    p_flags_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $onehot0({mode_int, mode_ext, training}));

    p_lock_ext_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        locked |-> mode_ext);

    p_shut_r10: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !shdn_n |=> !(training || mode_int || mode_ext));

endmodule

// File: tb/test_msync_top.sv
module test_msync_top;

    localparam int SIG_OUT  = 0;
    localparam int SIG_MOD  = 1;
    localparam int SIG_INT  = 2;
    localparam int SIG_EXT  = 3;
    localparam int SIG_TRN  = 4;
    localparam int SIG_LOCK = 5;

    typedef struct {
        int    due;
        int    sig;
        logic  val;
        string req;
    } item_t;

    logic osc_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic shdn_n  = 1'b0;
    logic sync_in = 1'b0;
    logic mod_clk, sync_out, mode_int, mode_ext, training, locked;

    int    cyc     = 0;
    int    checks  = 0;
    int    fails   = 0;
    bit    ext_en  = 1'b0;
    bit    track   = 1'b0;
    bit    done    = 1'b0;
    item_t sb[$];

    always #4 osc_clk = ~osc_clk;

    always @(posedge osc_clk) cyc <= cyc + 1;

    msync_top i_msync_top (
        .osc_clk  (osc_clk),
        .rst_n    (rst_n),
        .shdn_n   (shdn_n),
        .sync_in  (sync_in),
        .mod_clk  (mod_clk),
        .sync_out (sync_out),
        .mode_int (mode_int),
        .mode_ext (mode_ext),
        .training (training),
        .locked   (locked)
    );

    function automatic logic sig_val(int s);
        case (s)
            SIG_OUT:  return sync_out;
            SIG_MOD:  return mod_clk;
            SIG_INT:  return mode_int;
            SIG_EXT:  return mode_ext;
            SIG_TRN:  return training;
            default:  return locked;
        endcase
    endfunction

    function automatic string sig_name(int s);
        case (s)
            SIG_OUT:  return "sync_out";
            SIG_MOD:  return "mod_clk";
            SIG_INT:  return "mode_int";
            SIG_EXT:  return "mode_ext";
            SIG_TRN:  return "training";
            default:  return "locked";
        endcase
    endfunction

    task automatic expect_at(int due, int s, logic v, string req);
        item_t it;
        it.due = due;
        it.sig = s;
        it.val = v;
        it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compares every queued item in the cycle it is due
    always @(negedge osc_clk) begin : monitor
        item_t keep[$];
        item_t it;
        keep = {};
        while (sb.size() > 0) begin
            it = sb.pop_front();
            if (it.due == cyc) begin
                checks++;
                if (sig_val(it.sig) !== it.val) begin
                    fails++;
                    $display("FAIL %s: %s at edge %0d actual %b expected %b",
                             it.req, sig_name(it.sig), cyc, sig_val(it.sig), it.val);
                end
            end else begin
                keep.push_back(it);
            end
        end
        sb = keep;
    end

    // external clock source: half period of 5 osc_clk cycles
    initial begin : ext_gen
        int gcnt;
        gcnt = 0;
        forever begin
            @(negedge osc_clk);
            if (ext_en) begin
                if (gcnt == 0) sync_in = ~sync_in;
                gcnt = (gcnt == 4) ? 0 : gcnt + 1;
                if (track) begin
                    expect_at(cyc + 2, SIG_OUT, sync_in, "R6");
                    expect_at(cyc + 2, SIG_MOD, sync_in, "R6");
                end
            end else begin
                gcnt = 0;
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge osc_clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge osc_clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        int c, r, l, s, c2, e;
        step(2);
        rst_n = 1'b1;
        // R1: quiet while shut down
        for (int k = 0; k < 6; k++) expect_at(cyc + 1, k, 1'b0, "R1");
        step(3);

        // release with static sync_in
        c = cyc;
        shdn_n = 1'b1;
        expect_at(c + 2,   SIG_TRN, 1'b0, "R2");
        expect_at(c + 3,   SIG_TRN, 1'b1, "R2");
        expect_at(c + 256, SIG_TRN, 1'b1, "R2");
        expect_at(c + 257, SIG_TRN, 1'b0, "R2");
        expect_at(c + 10,  SIG_OUT, 1'b1, "R3");
        expect_at(c + 11,  SIG_OUT, 1'b0, "R3");
        expect_at(c + 10,  SIG_MOD, 1'b1, "R3");
        expect_at(c + 257, SIG_INT, 1'b1, "R4");
        expect_at(c + 257, SIG_EXT, 1'b0, "R4");
        expect_at(c + 258, SIG_OUT, 1'b0, "R4");
        expect_at(c + 270, SIG_OUT, 1'b0, "R4");
        expect_at(c + 258, SIG_MOD, 1'b1, "R4");
        expect_at(c + 259, SIG_MOD, 1'b0, "R4");
        step(300);

        // R7: sync_in starts toggling while in internal mode
        r = cyc;
        ext_en = 1'b1;
        expect_at(r + 5,  SIG_OUT, ((r + 5 - c) % 2 == 0) ? 1'b1 : 1'b0, "R7");
        expect_at(r + 6,  SIG_OUT, ((r + 6 - c) % 2 == 0) ? 1'b1 : 1'b0, "R7");
        expect_at(r + 6,  SIG_INT, 1'b1, "R7");
        expect_at(r + 40, SIG_LOCK, 1'b1, "R7");
        expect_at(r + 40, SIG_EXT, 1'b1, "R7");
        step(50);

        // R6: forwarding while locked
        track = 1'b1;
        step(30);
        track = 1'b0;
        step(3);

        // R8: external clock disappears
        l = cyc;
        ext_en = 1'b0;
        sync_in = 1'b0;
        expect_at(l + 2,  SIG_OUT, 1'b0, "R8");
        expect_at(l + 10, SIG_OUT, 1'b0, "R8");
        expect_at(l + 25, SIG_OUT, 1'b0, "R8");
        expect_at(l + 20, SIG_LOCK, 1'b1, "R8");
        expect_at(l + 50, SIG_LOCK, 1'b0, "R8");
        expect_at(l + 50, SIG_INT, 1'b1, "R8");
        step(60);

        // R10: shutdown from internal mode
        s = cyc;
        shdn_n = 1'b0;
        for (int k = 0; k < 6; k++) expect_at(s + 1, k, 1'b0, "R10");
        step(5);

        // R5: release with an external clock already present
        ext_en = 1'b1;
        step(20);
        c2 = cyc;
        shdn_n = 1'b1;
        expect_at(c2 + 3,   SIG_TRN, 1'b1, "R2");
        expect_at(c2 + 257, SIG_EXT, 1'b1, "R5");
        expect_at(c2 + 257, SIG_MOD, 1'b1, "R5");
        expect_at(c2 + 258, SIG_MOD, 1'b0, "R5");
        expect_at(c2 + 258, SIG_LOCK, 1'b0, "R5");
        expect_at(c2 + 290, SIG_LOCK, 1'b1, "R5");
        step(300);

        // R10: shutdown from external mode
        e = cyc;
        shdn_n = 1'b0;
        expect_at(e + 1, SIG_LOCK, 1'b0, "R10");
        expect_at(e + 1, SIG_EXT,  1'b0, "R10");
        expect_at(e + 1, SIG_MOD,  1'b0, "R10");
        expect_at(e + 1, SIG_OUT,  1'b0, "R10");
        step(5);
        ext_en = 1'b0;

        while (sb.size() > 0) step(1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule